// File: doc/BRIEF.md
# Two-Step Duplicated Adder With Comparison

This block adds two operands of twice the adder width by reusing a pair of identical half-width adders over two clock cycles. In the first step both adders work on the lower halves, and their sums and carry-outs are compared. In the second step both adders work on the upper halves, with the carry registered from the first step. Any difference between the two copies in either step raises an error flag. The flag is presented with the full result.

One adder, called A, is the designated copy. Its sum and its carry-out are the ones the block keeps. The other copy, called B, is used only for comparison. Each half-width adder is built from carry-lookahead groups, and the carry ripples from one group to the next.

Each copy has fault-injection inputs so that the comparison can be exercised. A sum mask is XORed onto that copy's sum bits, and a carry flip inverts its carry-out. Both are applied in both steps.

Top module: `dwc_split_adder`

## Requirements
- R1: While reset is low and after it is released, `sum`, `carry_out`, `err` and `done` are all 0 until the first operation completes.
- R2: A `start` sampled high in idle captures `op_a`, `op_b` and `carry_in`. `done` is then high for exactly one cycle, after the second rising edge that follows the capturing edge.
- R3: With no fault injected, `{carry_out, sum}` equals `op_a + op_b + carry_in` as a full-width sum, and `err` is 0.
- R4: The carry out of the lower-half addition enters the upper-half addition, so a carry generated in the lower half reaches the upper half of `sum`.
- R5: A `start` that arrives while an operation is in progress is ignored. The result and the timing of the running operation are unchanged.
- R6: A nonzero sum mask on either copy sets `err` to 1 in the result of that operation.
- R7: A carry flip on copy B alone sets `err` to 1 and leaves `sum` and `carry_out` equal to the fault-free result.
- R8: The result comes from copy A only, including the carry between the halves. With copy A's mask M and carry flip F, the result is computed as follows. The lower-half sum is the true lower sum XOR M. The step carry is the true lower carry XOR F. The upper half is added with that carry, and its sum is XORed with M and its carry-out with F.
- R9: `sum`, `carry_out` and `err` hold their values between completions. `err` reflects only the latest operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; acted on only when idle |
| op_a | input | 2*HALF_W | First operand |
| op_b | input | 2*HALF_W | Second operand |
| carry_in | input | 1 | Carry into the lowest bit |
| inj_sum_a | input | HALF_W | XOR mask on copy A sum |
| inj_carry_a | input | 1 | Inverts copy A carry-out |
| inj_sum_b | input | HALF_W | XOR mask on copy B sum |
| inj_carry_b | input | 1 | Inverts copy B carry-out |
| sum | output | 2*HALF_W | Result sum |
| carry_out | output | 1 | Result carry-out |
| err | output | 1 | Copies disagreed in either step |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The stimulus targets the carry crossing between the halves, using lower halves of all ones plus one and full-width all-ones operands. A design that dropped or mis-registered the step carry would return an upper half that is off by one. A second start is pulsed while an operation is running. A design that re-captured on it would return the sum of the second operands, or pulse `done` late. Carry-only faults on each copy separate a comparator that ignores carry-outs (no error on a B flip) from one that takes the step carry from the wrong copy (a corrupted sum on a B flip). A clean operation after a faulty one shows whether the error flag clears.

// File: rtl/dwc_pkg.sv
// Shared types for the two-step duplicated adder.
package dwc_pkg;
    // Sequencing phase: idle, lower-half step, upper-half step.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } dwc_phase_e;
endpackage

// File: rtl/dwc_cla_group.sv
// Carry-lookahead group of GW bits. Every internal carry is formed
// directly from generate/propagate terms and the group carry-in.
// Assumes GW is small (4 by default), since the term count grows quadratically.
module dwc_cla_group #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          ci,
    output logic [GW-1:0] s,
    output logic          co
);
    logic [GW-1:0] gen;
    logic [GW-1:0] prop;
    logic [GW:0]   cy;

    // Lookahead carries: c[i+1] = OR over j of g[j] & p[j+1..i], plus ci & p[0..i].
    always_comb begin : p_lookahead
        logic acc;
        logic term;
        gen   = a & b;
        prop  = a ^ b;
        cy[0] = ci;
        for (int i = 0; i < GW; i++) begin
            acc = ci;
            for (int k = 0; k <= i; k++) acc = acc & prop[k];
            for (int j = 0; j <= i; j++) begin
                term = gen[j];
                for (int k = j + 1; k <= i; k++) term = term & prop[k];
                acc = acc | term;
            end
            cy[i+1] = acc;
        end
    end

    assign s  = prop ^ cy[GW-1:0];
    assign co = cy[GW];
endmodule

// File: rtl/dwc_half_adder.sv
// Half-width adder copy: lookahead groups chained by a ripple carry.
// Fault injection is applied at the outputs: a mask XORs the sum and a
// flag inverts the carry-out. Assumes HALF_W is a multiple of GROUP_W.
module dwc_half_adder #(
    parameter int HALF_W  = 16,
    parameter int GROUP_W = 4
) (
    input  logic [HALF_W-1:0] a,
    input  logic [HALF_W-1:0] b,
    input  logic              ci,
    input  logic [HALF_W-1:0] inj_sum,
    input  logic              inj_carry,
    output logic [HALF_W-1:0] s,
    output logic              co
);
    localparam int NGRP = HALF_W / GROUP_W;

    logic [NGRP:0]     chain;
    logic [HALF_W-1:0] raw_sum;

    assign chain[0] = ci;

    // One lookahead group per slice; carry ripples between slices.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        dwc_cla_group #(.GW(GROUP_W)) u_grp (
            .a  (a[g*GROUP_W +: GROUP_W]),
            .b  (b[g*GROUP_W +: GROUP_W]),
            .ci (chain[g]),
            .s  (raw_sum[g*GROUP_W +: GROUP_W]),
            .co (chain[g+1])
        );
    end

    assign s  = raw_sum ^ inj_sum;
    assign co = chain[NGRP] ^ inj_carry;
endmodule

// File: rtl/dwc_compare.sv
// Equality check between the two adder copies, on sum and carry-out.
module dwc_compare #(
    parameter int W = 16
) (
    input  logic [W-1:0] s_a,
    input  logic [W-1:0] s_b,
    input  logic         c_a,
    input  logic         c_b,
    output logic         mismatch
);
    assign mismatch = (s_a != s_b) || (c_a != c_b);
endmodule

// File: rtl/dwc_phase_ctrl.sv
// Three-state sequencer: idle -> lower step -> upper step -> idle.
// start is honoured only in idle; it is ignored in the other states.
module dwc_phase_ctrl
    import dwc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output dwc_phase_e phase,
    output logic       load,
    output logic       low_step,
    output logic       high_step
);
    assign load      = (phase == ST_IDLE) && start;
    assign low_step  = (phase == ST_LOW);
    assign high_step = (phase == ST_HIGH);

    // Advance the phase once per cycle while an operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase <= ST_IDLE;
        else if (load)      phase <= ST_LOW;
        else if (low_step)  phase <= ST_HIGH;
        else if (high_step) phase <= ST_IDLE;
    end
endmodule

// File: rtl/dwc_split_adder.sv
// Top level: 2*HALF_W-bit adder built from two duplicated half-width
// copies reused over two cycles. Copy A supplies the kept result and the
// step carry; copy B is used for comparison only. Operands are captured on
// an accepted start, so they may change freely afterwards.
module dwc_split_adder
    import dwc_pkg::*;
#(
    parameter int HALF_W  = 16,
    parameter int GROUP_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2*HALF_W-1:0] op_a,
    input  logic [2*HALF_W-1:0] op_b,
    input  logic                carry_in,
    input  logic [HALF_W-1:0]   inj_sum_a,
    input  logic                inj_carry_a,
    input  logic [HALF_W-1:0]   inj_sum_b,
    input  logic                inj_carry_b,
    output logic [2*HALF_W-1:0] sum,
    output logic                carry_out,
    output logic                err,
    output logic                done
);
    localparam int FULL_W = 2 * HALF_W;

    dwc_phase_e        phase;
    logic              load, low_step, high_step;
    logic [FULL_W-1:0] a_q, b_q;
    logic              cin_q;
    logic [HALF_W-1:0] lo_q;
    logic              step_carry_q;
    logic              err_acc_q;
    logic [HALF_W-1:0] half_a, half_b;
    logic              add_ci;
    logic [HALF_W-1:0] s_cpy_a, s_cpy_b;
    logic              c_cpy_a, c_cpy_b;
    logic              mism;

    dwc_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .phase     (phase),
        .load      (load),
        .low_step  (low_step),
        .high_step (high_step)
    );

    // Choose which half feeds the adders, and which carry enters them.
    always_comb begin
        if (high_step) begin
            half_a = a_q[FULL_W-1:HALF_W];
            half_b = b_q[FULL_W-1:HALF_W];
            add_ci = step_carry_q;
        end else begin
            half_a = a_q[HALF_W-1:0];
            half_b = b_q[HALF_W-1:0];
            add_ci = cin_q;
        end
    end

    dwc_half_adder #(.HALF_W(HALF_W), .GROUP_W(GROUP_W)) u_add_a (
        .a         (half_a),
        .b         (half_b),
        .ci        (add_ci),
        .inj_sum   (inj_sum_a),
        .inj_carry (inj_carry_a),
        .s         (s_cpy_a),
        .co        (c_cpy_a)
    );

    dwc_half_adder #(.HALF_W(HALF_W), .GROUP_W(GROUP_W)) u_add_b (
        .a         (half_a),
        .b         (half_b),
        .ci        (add_ci),
        .inj_sum   (inj_sum_b),
        .inj_carry (inj_carry_b),
        .s         (s_cpy_b),
        .co        (c_cpy_b)
    );

    dwc_compare #(.W(HALF_W)) u_cmp (
        .s_a      (s_cpy_a),
        .s_b      (s_cpy_b),
        .c_a      (c_cpy_a),
        .c_b      (c_cpy_b),
        .mismatch (mism)
    );

    // Capture operands on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            cin_q <= 1'b0;
        end else if (load) begin
            a_q   <= op_a;
            b_q   <= op_b;
            cin_q <= carry_in;
        end
    end

    // Keep the lower-half result, the step carry and the first comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q         <= '0;
            step_carry_q <= 1'b0;
            err_acc_q    <= 1'b0;
        end else if (low_step) begin
            lo_q         <= s_cpy_a;
            step_carry_q <= c_cpy_a;
            err_acc_q    <= mism;
        end
    end

    // Publish the full result and a one-cycle done pulse after the upper step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum       <= '0;
            carry_out <= 1'b0;
            err       <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= high_step;
            if (high_step) begin
                sum       <= {s_cpy_a, lo_q};
                carry_out <= c_cpy_a;
                err       <= err_acc_q | mism;
            end
        end
    end
endmodule

// File: rtl/dwc_split_adder_chk.sv
// Property checker bound to the top level. It observes ports, the phase
// and the captured operands.
module dwc_split_adder_chk
    import dwc_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                done,
    input logic [2*HALF_W-1:0] sum,
    input logic                carry_out,
    input logic                err,
    input dwc_phase_e          phase,
    input logic [2*HALF_W-1:0] a_q,
    input logic [2*HALF_W-1:0] b_q,
    input logic                cin_q,
    input logic [HALF_W-1:0]   inj_sum_a,
    input logic                inj_carry_a,
    input logic [HALF_W-1:0]   inj_sum_b,
    input logic                inj_carry_b
);
    logic [2*HALF_W:0] exp_full;
    logic              no_fault;
    logic              any_mask;

    assign exp_full = {1'b0, a_q} + {1'b0, b_q} + {{(2*HALF_W){1'b0}}, cin_q};
    assign no_fault = (inj_sum_a == '0) && (inj_sum_b == '0) && !inj_carry_a && !inj_carry_b;
    assign any_mask = (inj_sum_a != '0) || (inj_sum_b != '0);

    // R1: reset leaves the outputs cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (done == 1'b0 && err == 1'b0 && sum == '0 && carry_out == 1'b0));

    // R2: done lasts one cycle.
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: done follows the upper step.
    a_r2_done_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(phase == ST_HIGH));

    // R5: start during the lower step does not restart.
    a_r5_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_LOW && start) |=> phase == ST_HIGH);

    // R3: fault-free operation yields the arithmetic sum with no error.
    a_r3_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(no_fault) && $past(no_fault, 2)) |-> ({carry_out, sum} == exp_full && !err));

    // R6: a sum mask during the upper step is always reported.
    a_r6_err_on_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(any_mask)) |-> err);

    // R9: outputs hold between completions.
    a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(sum) && $stable(carry_out) && $stable(err)));
endmodule

bind dwc_split_adder dwc_split_adder_chk #(.HALF_W(HALF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .done        (done),
    .sum         (sum),
    .carry_out   (carry_out),
    .err         (err),
    .phase       (phase),
    .a_q         (a_q),
    .b_q         (b_q),
    .cin_q       (cin_q),
    .inj_sum_a   (inj_sum_a),
    .inj_carry_a (inj_carry_a),
    .inj_sum_b   (inj_sum_b),
    .inj_carry_b (inj_carry_b)
);

// File: tb/sim_dwc_split_adder.sv
// Self-checking bench: directed corner cases plus seeded random operations.
module sim_dwc_split_adder;
    localparam int HW = 16;
    localparam int FW = 2 * HW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [FW-1:0] op_a = '0, op_b = '0;
    logic          carry_in = 1'b0;
    logic [HW-1:0] inj_sum_a = '0, inj_sum_b = '0;
    logic          inj_carry_a = 1'b0, inj_carry_b = 1'b0;
    logic [FW-1:0] sum;
    logic          carry_out, err, done;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dwc_split_adder #(.HALF_W(HW), .GROUP_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .inj_sum_a(inj_sum_a), .inj_carry_a(inj_carry_a),
        .inj_sum_b(inj_sum_b), .inj_carry_b(inj_carry_b), .sum(sum),
        .carry_out(carry_out), .err(err), .done(done)
    );

    // Result predicted from the requirements (R3, R4, R8): copy A faults only.
    function automatic logic [FW:0] model(input logic [FW-1:0] a, input logic [FW-1:0] b,
                                          input logic ci, input logic [HW-1:0] m,
                                          input logic f);
        logic [HW:0] lo, hi;
        logic        mid;
        lo  = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, ci};
        mid = lo[HW] ^ f;
        hi  = {1'b0, a[FW-1:HW]} + {1'b0, b[FW-1:HW]} + {{HW{1'b0}}, mid};
        return {hi[HW] ^ f, hi[HW-1:0] ^ m, lo[HW-1:0] ^ m};
    endfunction

    // Expected error flag (R6, R7).
    function automatic logic exp_err(input logic [HW-1:0] ma, input logic fa,
                                     input logic [HW-1:0] mb, input logic fb);
        return (ma != '0) || (mb != '0) || fa || fb;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation. Inputs change at falling edges; checks sample there too.
    task automatic do_op(input logic [FW-1:0] ta, input logic [FW-1:0] tb, input logic tc,
                         input logic [HW-1:0] ma, input logic fa,
                         input logic [HW-1:0] mb, input logic fb,
                         input bit poke_busy, input string req);
        logic [FW:0] exp_full;
        logic        exp_e;
        exp_full = model(ta, tb, tc, ma, fa);
        exp_e    = exp_err(ma, fa, mb, fb);
        @(negedge clk);
        op_a = ta; op_b = tb; carry_in = tc;
        inj_sum_a = ma; inj_carry_a = fa; inj_sum_b = mb; inj_carry_b = fb;
        start = 1'b1;
        @(negedge clk);                      // capture edge passed
        start = poke_busy;                   // R5: second start while busy
        op_a = ~ta; op_b = ta ^ tb; carry_in = ~tc;
        check(done == 1'b0, "R2 early done", {63'd0, done}, 64'd0);
        @(negedge clk);                      // lower step done
        start = 1'b0;
        check(done == 1'b0, "R2 early done", {63'd0, done}, 64'd0);
        @(negedge clk);                      // upper step done
        check(done == 1'b1, "R2 done pulse", {63'd0, done}, 64'd1);
        check({carry_out, sum} == exp_full, req, {31'd0, carry_out, sum}, {31'd0, exp_full});
        check(err == exp_e, {req, " err"}, {63'd0, err}, {63'd0, exp_e});
        inj_sum_a = '0; inj_carry_a = 1'b0; inj_sum_b = '0; inj_carry_b = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R2 single pulse", {63'd0, done}, 64'd0);
        check({carry_out, sum} == exp_full && err == exp_e, "R9 hold",
              {31'd0, carry_out, sum}, {31'd0, exp_full});
    endtask

    initial begin
        logic [FW-1:0] ra, rb;
        logic [HW-1:0] rma, rmb;
        logic          rfa, rfb;
        int            sel;
        void'($urandom(32'hC0DE_1234));
        repeat (3) @(negedge clk);
        check(sum == '0 && carry_out == 1'b0 && err == 1'b0 && done == 1'b0, "R1 reset",
              {31'd0, carry_out, sum}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sum == '0 && err == 1'b0 && done == 1'b0, "R1 after reset",
              {31'd0, carry_out, sum}, 64'd0);

        do_op('0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R3 zeros");
        do_op('1, '0, 1'b1, '0, 1'b0, '0, 1'b0, 1'b0, "R3 all ones plus carry");
        do_op(32'h0000_FFFF, 32'h0000_0001, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R4 lower carry");
        do_op(32'h1234_FFFF, 32'h0000_0000, 1'b1, '0, 1'b0, '0, 1'b0, 1'b0, "R4 carry-in ripple");
        do_op(32'hDEAD_BEEF, 32'h1111_2222, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, "R5 busy start");
        do_op(32'h0F0F_0F0F, 32'h1010_1010, 1'b0, 16'h0004, 1'b0, '0, 1'b0, 1'b0, "R6 mask A");
        do_op(32'h0F0F_0F0F, 32'h1010_1010, 1'b0, '0, 1'b0, 16'h8000, 1'b0, 1'b0, "R6 mask B");
        do_op(32'h0000_FFFF, 32'h0000_0001, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R7 carry B");
        do_op(32'h0000_FFFF, 32'h0000_0001, 1'b0, '0, 1'b1, '0, 1'b0, 1'b0, "R8 carry A");
        do_op(32'h0000_0001, 32'h0000_0001, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R9 err clears");

        for (int i = 0; i < 400; i++) begin
            ra = $urandom; rb = $urandom;
            rma = '0; rmb = '0; rfa = 1'b0; rfb = 1'b0;
            sel = $urandom_range(0, 7);
            case (sel)
                1: rma = HW'($urandom_range(1, 65535));
                2: rmb = HW'($urandom_range(1, 65535));
                3: rfa = 1'b1;
                4: rfb = 1'b1;
                default: ;
            endcase
            if (sel == 5) rb[HW-1:0] = ~ra[HW-1:0];
            do_op(ra, rb, 1'($urandom), rma, rfa, rmb, rfb, (sel == 6), "R8 random");
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule